// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer and Event Counter

This block is a 16-bit up-counter with a reload value, driven by the system clock and controlled through a small byte-wide register bus. The counter has three count sources. In the periodic mode it takes one step for every four system clocks. In the event mode it counts the chosen edge of an external pin. In the width mode it times one pulse on that pin and then turns itself off. When the count passes the all-ones value, the counter takes the reload value and raises an overflow flag. That flag drives an interrupt line only when the interrupt line is enabled.

The 16-bit counter and reload value are reached through 8-bit accesses with a shared low-byte holding register, so that software always sees a consistent 16-bit pair. A low-byte write only fills the holding register. A high-byte write commits both bytes at once. A high-byte read returns the upper byte of the live count and freezes the lower byte into the holding register, where a later low-byte read picks it up. The register bus is a plain strobe interface with no back-pressure: a write takes effect at the clock edge where `bus_wr_en` is high, and read data appears one clock after `bus_rd_en`.

Top module: `tmr16_unit`

## Requirements
- R1: After reset, the counter, the reload value, the low-byte holding register, the control register, the overflow flag, `irq` and `bus_rdata` are all zero.
- R2: Bus addresses select the registers as follows: 0 is the low byte, 1 is the high byte and 2 is control. A write to address 0 changes only the holding register. A write to address 1 loads {wdata, holding} into the reload value. If count enable (control bit 4) is 0, that write also loads {wdata, holding} into the counter.
- R3: While count enable is 1, a write to address 1 updates only the reload value. The counter continues its sequence unchanged.
- R4: A read of address 1 returns counter[15:8] on `bus_rdata` one clock after the strobe and copies counter[7:0] into the holding register in the same edge. A read of address 0 returns the holding register. A read of address 2 returns {control[7:1], overflow flag}.
- R5: Control bits [7:6] hold the mode: 00 off, 01 event, 10 periodic, 11 width. In the periodic mode the counter advances once every 4 system clocks while count enable is 1.
- R6: In the event mode the counter advances once per pin edge. The edge is rising when control bit 3 is 1 and falling when it is 0. The other edge has no effect.
- R7: A count step taken at 0xFFFF loads the reload value into the counter and sets the overflow flag.
- R8: A write to address 2 with bit 0 set clears the overflow flag. An overflow in the same cycle wins. `irq` is high only while the flag is set and control bit 5 (interrupt enable) is 1.
- R9: In the width mode, a control write with count enable 1 arms a measurement, but only if the synchronized pin is at the level before the start edge (low when bit 3 is 1, high when bit 3 is 0). An armed unit counts one step per 4 clocks from the start edge until the pin returns to its level, and then hardware clears count enable.
- R10: A finished width result is held through any further pin pulses until count enable is written to 1 again. A new measurement then continues from the held count.
- R11: While count enable is 0 and no high-byte write occurs, the counter does not change in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after a read strobe |
| evt_pin | input | 1 | External event / pulse input, asynchronous |
| ovf_flag | output | 1 | Overflow request flag |
| irq | output | 1 | Overflow flag gated by the interrupt enable |

## Verification
Each result has a fixed delay. Register writes show at the edge where the strobe is sampled. Read data is valid one edge after the read strobe. A pin change reaches the counter on the third rising edge after it, because it passes two synchronizer flops and an edge register. The bench drives every input at falling edges and compares read data at the falling edge that follows the read edge. It waits at least six clocks after each pin change before it looks at the count. The periodic and width results are exact. For the periodic test, the bench keeps count enable high for exactly 40 edges. For the width test, the pin is high for exactly 40 clocks, and both pin edges take the same delay. Either window holds exactly ten divide-by-4 steps, whatever the phase of the divider.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    MD_OFF   = 2'b00,
    MD_EVENT = 2'b01,
    MD_TIMER = 2'b10,
    MD_WIDTH = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    PW_IDLE  = 2'b00,
    PW_ARMED = 2'b01,
    PW_MEAS  = 2'b10,
    PW_DONE  = 2'b11
  } pw_state_e;

  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  localparam int CTL_MODE_HI = 7;
  localparam int CTL_MODE_LO = 6;
  localparam int CTL_IEN     = 5;
  localparam int CTL_RUN     = 4;
  localparam int CTL_EDGE    = 3;
  localparam int CTL_CLRF    = 0;

endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick_o = &div_q;
endmodule

// File: rtl/tmr16_pw_fsm.sv
module tmr16_pw_fsm
  import tmr16_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic pre_ok_i,
  input  logic disarm_i,
  input  logic start_i,
  input  logic end_i,
  output logic meas_o,
  output logic done_o
);
  pw_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PW_IDLE;
    end else if (arm_i) begin
      st_q <= pre_ok_i ? PW_ARMED : PW_IDLE;
    end else if (disarm_i) begin
      st_q <= PW_IDLE;
    end else begin
      unique case (st_q)
        PW_ARMED: if (start_i) st_q <= PW_MEAS;
        PW_MEAS:  if (end_i)   st_q <= PW_DONE;
        default:  st_q <= st_q;
      endcase
    end
  end

  assign meas_o = (st_q == PW_MEAS);
  assign done_o = (st_q == PW_MEAS) && end_i && !arm_i && !disarm_i;
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             evt_pin,
  output logic             ovf_flag,
  output logic             irq
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt_q, preload_q;
  logic [BUS_W-1:0] lo_buf_q;
  logic [7:1]       ctl_q;
  logic             flag_q;
  logic [BUS_W-1:0] rdata_q;

  logic pin_lvl, pin_rise, pin_fall, div_tick;
  logic pw_meas, pw_done;

  tmr_mode_e mode;
  logic      run_en, edge_sel, int_en;
  logic      wr_lo, wr_hi, wr_ctl, rd_hi;
  logic      step_src, cnt_en, cnt_wrap;
  logic      arm, disarm, pre_ok;

  assign mode     = tmr_mode_e'(ctl_q[CTL_MODE_HI:CTL_MODE_LO]);
  assign run_en   = ctl_q[CTL_RUN];
  assign edge_sel = ctl_q[CTL_EDGE];
  assign int_en   = ctl_q[CTL_IEN];

  assign wr_lo  = bus_wr_en && (bus_addr == ADDR_LO);
  assign wr_hi  = bus_wr_en && (bus_addr == ADDR_HI);
  assign wr_ctl = bus_wr_en && (bus_addr == ADDR_CTL);
  assign rd_hi  = bus_rd_en && (bus_addr == ADDR_HI);

  tmr16_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (evt_pin),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  tmr16_prescale #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (div_tick)
  );

  // Arming uses the edge select being written, so TE and TON land together.
  assign arm    = wr_ctl && bus_wdata[CTL_RUN]
                  && (bus_wdata[CTL_MODE_HI:CTL_MODE_LO] == MD_WIDTH);
  assign disarm = wr_ctl && !arm;
  assign pre_ok = (pin_lvl != bus_wdata[CTL_EDGE]);

  tmr16_pw_fsm u_pw (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .pre_ok_i (pre_ok),
    .disarm_i (disarm),
    .start_i  (edge_sel ? pin_rise : pin_fall),
    .end_i    (edge_sel ? pin_fall : pin_rise),
    .meas_o   (pw_meas),
    .done_o   (pw_done)
  );

  always_comb begin
    unique case (mode)
      MD_EVENT: step_src = edge_sel ? pin_rise : pin_fall;
      MD_TIMER: step_src = div_tick;
      MD_WIDTH: step_src = div_tick && pw_meas;
      default:  step_src = 1'b0;
    endcase
  end

  assign cnt_en   = run_en && step_src;
  assign cnt_wrap = cnt_en && (&cnt_q);

  // Counter and reload value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      preload_q <= '0;
    end else begin
      if (wr_hi) preload_q <= {bus_wdata[HI_W-1:0], lo_buf_q};
      if (wr_hi && !run_en)  cnt_q <= {bus_wdata[HI_W-1:0], lo_buf_q};
      else if (cnt_wrap)     cnt_q <= preload_q;
      else if (cnt_en)       cnt_q <= cnt_q + 1'b1;
    end
  end

  // Shared low-byte holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_buf_q <= '0;
    else if (wr_lo) lo_buf_q <= bus_wdata;
    else if (rd_hi) lo_buf_q <= cnt_q[BUS_W-1:0];
  end

  // Control register, flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctl)       ctl_q <= bus_wdata[7:1];
      else if (pw_done) ctl_q[CTL_RUN] <= 1'b0;
      if (cnt_wrap)                            flag_q <= 1'b1;
      else if (wr_ctl && bus_wdata[CTL_CLRF])  flag_q <= 1'b0;
    end
  end

  // Read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd_en) begin
      unique case (bus_addr)
        ADDR_LO:  rdata_q <= lo_buf_q;
        ADDR_HI:  rdata_q <= {{(BUS_W-HI_W){1'b0}}, cnt_q[CNT_W-1:BUS_W]};
        ADDR_CTL: rdata_q <= {ctl_q, flag_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign ovf_flag  = flag_q;
  assign irq       = flag_q && int_en;
endmodule

// File: rtl/tmr16_unit_chk.sv
module tmr16_unit_chk
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr_en,
  input logic             bus_rd_en,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preload,
  input logic             run_en,
  input logic             cnt_en,
  input logic             ovf_flag,
  input logic             irq
);
  logic hi_wr, hi_rd;
  assign hi_wr = bus_wr_en && (bus_addr == ADDR_HI);
  assign hi_rd = bus_rd_en && (bus_addr == ADDR_HI);

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !hi_wr) |=> $stable(cnt)); // R11

  AST_RUN_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_en && hi_wr) |=> $stable(cnt)); // R3

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (&cnt) && !hi_wr) |=> (cnt == $past(preload))); // R7

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (&cnt)) |=> ovf_flag); // R7

  AST_HI_READ: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> (bus_rdata[CNT_W-BUS_W-1:0] == $past(cnt[CNT_W-1:BUS_W]))); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag); // R8
endmodule

bind tmr16_unit tmr16_unit_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .cnt       (cnt_q),
  .preload   (preload_q),
  .run_en    (run_en),
  .cnt_en    (cnt_en),
  .ovf_flag  (ovf_flag),
  .irq       (irq)
);

// File: tb/tmr16_unit_tb.sv
module tmr16_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0;
  logic       bus_rd_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       evt_pin = 1'b0;
  logic       ovf_flag, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];
  logic     rd_seen = 1'b0;

  always #4 clk = ~clk;

  tmr16_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pin   (evt_pin),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
  );

  // Monitor: a read strobe seen at an edge has data due at the next falling edge
  always @(posedge clk) rd_seen <= bus_rd_en;

  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s rdata=%02h expected=%02h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [15:0] e, input string tag);
    rd(2'd1, e[15:8], tag);
    rd(2'd0, e[7:0], tag);
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, e);
    end
  endtask

  task automatic load16(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic pin_pulse(input int hi, input int lo);
    @(negedge clk); evt_pin = 1'b1;
    repeat (hi) @(negedge clk);
    evt_pin = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ovf_flag, 1'b0, "R1 flag in reset");
    chk(irq, 1'b0, "R1 irq in reset");
    chk(bus_rdata == 8'h00, 1'b1, "R1 rdata in reset");
    rst_n = 1'b1;
    rd(2'd2, 8'h00, "R1 control");
    rd16(16'h0000, "R1 counter");

    // R2: low write goes to the buffer only
    wr(2'd0, 8'h34);
    rd(2'd0, 8'h34, "R2 low write buffered");
    rd(2'd1, 8'h00, "R2 counter untouched by low write");
    load16(16'h1234);
    rd16(16'h1234, "R2 stopped high write loads counter");

    // R11: periodic mode with enable off
    wr(2'd2, 8'h80);
    repeat (20) @(negedge clk);
    rd16(16'h1234, "R11 held while stopped");

    // R5: exactly 40 running edges gives 10 steps
    load16(16'h0000);
    wr(2'd2, 8'h90);
    repeat (38) @(negedge clk);
    wr(2'd2, 8'h80);
    rd16(16'h000A, "R5 periodic divide by 4");

    // R6: rising edges
    wr(2'd2, 8'h40);
    load16(16'h0000);
    wr(2'd2, 8'h58);
    for (int i = 0; i < 5; i++) pin_pulse(3, 3);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'h40);
    rd16(16'h0005, "R6 rising edges counted");

    // R6: falling edge selected, rise ignored
    load16(16'h0000);
    wr(2'd2, 8'h50);
    @(negedge clk); evt_pin = 1'b1;
    repeat (8) @(negedge clk);
    rd16(16'h0000, "R6 rise ignored when falling selected");
    evt_pin = 1'b0;
    repeat (8) @(negedge clk);
    rd16(16'h0001, "R6 falling edge counted");

    // R3 / R7 / R8
    wr(2'd2, 8'h40);
    load16(16'hFFFE);
    wr(2'd2, 8'h78);
    load16(16'h1234);
    rd16(16'hFFFE, "R3 running write leaves counter");
    pin_pulse(3, 6);
    chk(ovf_flag, 1'b0, "R7 no flag before wrap");
    rd16(16'hFFFF, "R7 at top");
    pin_pulse(3, 6);
    chk(ovf_flag, 1'b1, "R7 flag on wrap");
    chk(irq, 1'b1, "R8 irq with enable");
    rd16(16'h1234, "R7 reload value on wrap");
    wr(2'd2, 8'h58);
    chk(irq, 1'b0, "R8 irq masked");
    chk(ovf_flag, 1'b1, "R8 flag kept when masked");
    wr(2'd2, 8'h59);
    chk(ovf_flag, 1'b0, "R8 flag cleared");

    // R9: width measurement, 40 clocks high
    wr(2'd2, 8'h40);
    load16(16'h0000);
    wr(2'd2, 8'hD8);
    repeat (4) @(negedge clk);
    pin_pulse(40, 10);
    rd(2'd2, 8'hC8, "R9 enable self-cleared");
    rd16(16'h000A, "R9 width result");

    // R10: held through another pulse, then re-armed
    pin_pulse(40, 10);
    rd16(16'h000A, "R10 result held");
    wr(2'd2, 8'hD8);
    repeat (4) @(negedge clk);
    pin_pulse(20, 10);
    rd16(16'h000F, "R10 re-armed continues");

    // R9: arming refused when pin already high
    @(negedge clk); evt_pin = 1'b1;
    repeat (6) @(negedge clk);
    wr(2'd2, 8'hD8);
    evt_pin = 1'b0;
    repeat (6) @(negedge clk);
    pin_pulse(20, 10);
    rd16(16'h000F, "R9 not armed at wrong level");
    rd(2'd2, 8'hD8, "R9 enable stays set");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule